// File: doc/BRIEF.md
# Thermal Trip Shutdown Comparator

This block turns a stream of periodic per-channel temperature conversions into a single active-low system shutdown signal. Each conversion arrives as an integer-degree value tagged with its channel number and qualified by a valid strobe. Each channel compares its value against two thresholds. One is the hardware trip point, which applies to channels picked by a board strap. The other is the channel's own software limit, which applies only when its enable bit is set.

A channel is counted as faulted only after a programmable run of consecutive out-of-limit conversions, so a single noisy reading cannot shut the system down. The strap is read once on the first clock edge after reset and then held. No software setting can stop a strap-selected channel from driving the shutdown. The shutdown releases when every channel that holds it receives a conversion that is not above its limits.

Top module: `therm_trip_guard`

## Requirements
- R1: After reset `shdn_no` is 1 and every channel's run count is zero, so a fresh run needs the full queue length to trip.
- R2: Values are unsigned integer degrees. A conversion is out of limit only when it is strictly greater than the threshold; a value equal to the threshold counts as a pass.
- R3: `queue_i` sets the run length: 2'b00 = 1, 2'b01 = 2, 2'b10 = 3, 2'b11 = 4 consecutive out-of-limit conversions. `shdn_no` goes to 0 in the cycle after the clock edge that accepts the conversion completing the run.
- R4: A passing conversion on a channel clears that channel's run count, so out-of-limit conversions separated by a pass never add up.
- R5: The strap code `strap_i` selects the hardware-checked channels: 2'b00 (tied low) selects channel 0, 2'b01 (tied high) selects channel 1, 2'b10 (open) selects channels 0 and 1, and 2'b11 is treated as open. The code is captured on the first clock edge after reset, and later changes have no effect.
- R6: On a strap-selected channel, a value above `trip_i` drives the shutdown whatever `sw_en_i` and `sw_limit_i` hold. A channel that is neither strap-selected nor software-enabled never drives the shutdown.
- R7: When `sw_en_i[n]` is 1, channel n is also out of limit when its value exceeds `sw_limit_i[8n+7:8n]`. The same queue rule applies.
- R8: `shdn_no` returns to 1 in the cycle after the last faulted channel receives a passing conversion. While any other channel is still faulted, it stays 0.
- R9: Run counts are kept per channel. Conversions for other channels interleaved between them do not break a channel's consecutive run.
- R10: Values presented while `sample_valid_i` is 0 have no effect on any run count or on `shdn_no`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 2 | Decoded three-state strap code (R5) |
| queue_i | input | 2 | Consecutive-fault run length code (R3) |
| trip_i | input | 8 | Hardware trip point, integer degrees |
| sw_en_i | input | 4 | Per-channel software limit enables |
| sw_limit_i | input | 32 | Per-channel software limits, channel n in bits 8n+7:8n |
| sample_valid_i | input | 1 | Conversion strobe |
| sample_ch_i | input | 2 | Channel of the current conversion |
| sample_temp_i | input | 8 | Converted temperature, integer degrees |
| shdn_no | output | 1 | Active-low system shutdown |

## Verification
The bench runs every queue code and checks that the output falls exactly on the Nth fault and not one early. A design with an off-by-one in the run decode would shut down too soon or too late. It places a conversion equal to the trip point inside a run; a design using greater-or-equal would trip there, and one that fails to clear the count on a pass would trip on faults that are not consecutive. It also changes the strap after the capture edge, interleaves other channels within a run, and holds two channels faulted at once. These catch a design that keeps following the strap pin, one that keeps a single shared count, and one that releases as soon as the first channel recovers.

// File: rtl/ttg_pkg.sv
package ttg_pkg;
  typedef enum logic [1:0] {
    STRAP_LOW  = 2'b00,
    STRAP_HIGH = 2'b01,
    STRAP_OPEN = 2'b10,
    STRAP_RSVD = 2'b11
  } strap_e;

  localparam int unsigned QUEUE_W = 2;
  localparam int unsigned MAX_RUN = 1 << QUEUE_W;
  localparam int unsigned RUN_W   = $clog2(MAX_RUN + 1);
endpackage

// File: rtl/ttg_strap_latch.sv
module ttg_strap_latch
  import ttg_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter logic [NUM_CH-1:0] MASK_LOW  = NUM_CH'(1),
  parameter logic [NUM_CH-1:0] MASK_HIGH = NUM_CH'(2),
  parameter logic [NUM_CH-1:0] MASK_OPEN = NUM_CH'(3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_i,
  output logic [NUM_CH-1:0] hw_mask_o
);
  logic   taken_q;
  strap_e strap_q;
  strap_e strap_cur;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      strap_q <= STRAP_LOW;
    end else if (!taken_q) begin
      taken_q <= 1'b1;
      strap_q <= strap_e'(strap_i);
    end
  end

  // before the capture edge the live strap is used
  assign strap_cur = taken_q ? strap_q : strap_e'(strap_i);

  always_comb begin
    unique case (strap_cur)
      STRAP_LOW:  hw_mask_o = MASK_LOW;
      STRAP_HIGH: hw_mask_o = MASK_HIGH;
      default:    hw_mask_o = MASK_OPEN;
    endcase
  end

  p_strap_held_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_q |=> ($stable(strap_q) && taken_q));
endmodule

// File: rtl/ttg_fault_queue.sv
module ttg_fault_queue
  import ttg_pkg::*;
#(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] trip_i,
  input  logic [TEMP_W-1:0] limit_i,
  input  logic              hw_sel_i,
  input  logic              sw_en_i,
  input  logic [RUN_W-1:0]  need_i,
  output logic              trip_o
);
  logic [RUN_W-1:0] cnt_q, cnt_nxt;
  logic             over;

  assign over = (hw_sel_i && (temp_i > trip_i)) || (sw_en_i && (temp_i > limit_i));

  always_comb begin
    if (!over)                      cnt_nxt = '0;
    else if (cnt_q == RUN_W'(MAX_RUN)) cnt_nxt = cnt_q;
    else                            cnt_nxt = cnt_q + RUN_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      trip_o <= 1'b0;
    end else if (hit_i) begin
      cnt_q  <= cnt_nxt;
      trip_o <= over && (cnt_nxt >= need_i);
    end
  end

  p_pass_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !over) |=> (cnt_q == '0 && !trip_o));
  p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i |=> ($stable(cnt_q) && $stable(trip_o)));
  p_run_sat_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RUN_W'(MAX_RUN));
  p_trip_on_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(hit_i));
endmodule

// File: rtl/therm_trip_guard.sv
module therm_trip_guard
  import ttg_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               strap_i,
  input  logic [QUEUE_W-1:0]       queue_i,
  input  logic [TEMP_W-1:0]        trip_i,
  input  logic [NUM_CH-1:0]        sw_en_i,
  input  logic [NUM_CH*TEMP_W-1:0] sw_limit_i,
  input  logic                     sample_valid_i,
  input  logic [CH_W-1:0]          sample_ch_i,
  input  logic [TEMP_W-1:0]        sample_temp_i,
  output logic                     shdn_no
);
  logic [NUM_CH-1:0] hw_mask;
  logic [NUM_CH-1:0] trip_vec;
  logic [RUN_W-1:0]  need;

  assign need = RUN_W'(queue_i) + RUN_W'(1);

  ttg_strap_latch #(.NUM_CH(NUM_CH)) u_strap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_i),
    .hw_mask_o (hw_mask)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = sample_valid_i && (sample_ch_i == CH_W'(g));

    ttg_fault_queue #(.TEMP_W(TEMP_W)) u_q (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit),
      .temp_i   (sample_temp_i),
      .trip_i   (trip_i),
      .limit_i  (sw_limit_i[g*TEMP_W +: TEMP_W]),
      .hw_sel_i (hw_mask[g]),
      .sw_en_i  (sw_en_i[g]),
      .need_i   (need),
      .trip_o   (trip_vec[g])
    );
  end

  assign shdn_no = ~|trip_vec;

  p_release_on_sample_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shdn_no) |-> $past(sample_valid_i));
  p_assert_on_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(shdn_no) |-> $past(sample_valid_i));
  p_one_channel_per_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(trip_vec ^ $past(trip_vec)) <= 1);
endmodule

// File: tb/tb_therm_trip_guard.sv
module tb_therm_trip_guard;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  strap_i = 2'b00;
  logic [1:0]  queue_i = 2'b00;
  logic [7:0]  trip_i = 8'd80;
  logic [3:0]  sw_en_i = 4'b0000;
  logic [31:0] sw_limit_i = '1;
  logic        sample_valid_i = 1'b0;
  logic [1:0]  sample_ch_i = 2'd0;
  logic [7:0]  sample_temp_i = 8'd0;
  logic        shdn_no;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  therm_trip_guard dut (
    .clk_i(clk), .rst_ni(rst_ni), .strap_i(strap_i), .queue_i(queue_i),
    .trip_i(trip_i), .sw_en_i(sw_en_i), .sw_limit_i(sw_limit_i),
    .sample_valid_i(sample_valid_i), .sample_ch_i(sample_ch_i),
    .sample_temp_i(sample_temp_i), .shdn_no(shdn_no)
  );

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (shdn_no !== exp) begin
      failures++;
      $display("FAIL %s: shdn_no=%0b expected %0b", tag, shdn_no, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] strap);
    @(negedge clk);
    rst_ni = 1'b0;
    strap_i = strap;
    queue_i = 2'b00;
    trip_i = 8'd80;
    sw_en_i = '0;
    sw_limit_i = '1;
    sample_valid_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic conv(input int ch, input int t);
    @(negedge clk);
    sample_valid_i = 1'b1;
    sample_ch_i = 2'(ch);
    sample_temp_i = 8'(t);
    @(negedge clk);
    sample_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    chk(1'b1, "R1 reset state");
    queue_i = 2'b11;
    conv(0, 90); conv(0, 90); conv(0, 90);
    chk(1'b1, "R1 counts start at zero");
    conv(0, 90);
    chk(1'b0, "R1 full run from reset");
  endtask

  task automatic t_queue();
    for (int q = 0; q < 4; q++) begin
      do_reset(2'b00);
      queue_i = 2'(q);
      for (int n = 1; n <= q + 1; n++) begin
        conv(0, 81);
        chk((n == q + 1) ? 1'b0 : 1'b1, $sformatf("R3 queue=%0d fault %0d", q, n));
      end
      conv(0, 80);
      chk(1'b1, "R8 release on equal value");
    end
  endtask

  task automatic t_equal();
    do_reset(2'b00);
    for (int n = 0; n < 4; n++) conv(0, 80);
    chk(1'b1, "R2 equal to trip is a pass");
    conv(0, 81);
    chk(1'b0, "R2 one above trip faults");
  endtask

  task automatic t_break();
    do_reset(2'b00);
    queue_i = 2'b10;
    conv(0, 95); conv(0, 95); conv(0, 70);
    conv(0, 95); conv(0, 95);
    chk(1'b1, "R4 pass breaks run");
    conv(0, 95);
    chk(1'b0, "R4 third consecutive after pass");
  endtask

  task automatic t_interleave();
    do_reset(2'b00);
    queue_i = 2'b01;
    conv(0, 90);
    conv(2, 20);
    conv(3, 200);
    conv(0, 90);
    chk(1'b0, "R9 other channels keep run");
  endtask

  task automatic t_strap();
    do_reset(2'b01);
    conv(0, 120);
    chk(1'b1, "R5 high strap ignores ch0");
    conv(1, 81);
    chk(1'b0, "R5 high strap checks ch1");
    strap_i = 2'b00;
    conv(1, 50);
    chk(1'b1, "R8 ch1 pass releases");
    conv(0, 120);
    chk(1'b1, "R5 later strap change ignored");
    conv(1, 81);
    chk(1'b0, "R5 latched strap still ch1");
    do_reset(2'b10);
    conv(0, 81);
    chk(1'b0, "R5 open strap checks ch0");
    conv(0, 10);
    conv(1, 81);
    chk(1'b0, "R5 open strap checks ch1");
    do_reset(2'b11);
    conv(1, 81);
    chk(1'b0, "R5 code 11 acts as open");
  endtask

  task automatic t_sw();
    do_reset(2'b00);
    sw_en_i = 4'b0100;
    sw_limit_i[23:16] = 8'd60;
    conv(2, 61);
    chk(1'b0, "R7 sw limit exceeded");
    conv(2, 60);
    chk(1'b1, "R7 sw limit equal passes");
    sw_en_i = 4'b0000;
    conv(2, 150);
    chk(1'b1, "R6 unselected disabled ch2 ignored");
    conv(3, 250);
    chk(1'b1, "R6 unselected disabled ch3 ignored");
    sw_en_i = 4'b0001;
    sw_limit_i[7:0] = 8'd250;
    conv(0, 81);
    chk(1'b0, "R6 hw path not masked by sw");
  endtask

  task automatic t_two();
    do_reset(2'b10);
    conv(0, 90);
    conv(1, 90);
    chk(1'b0, "R8 two channels faulted");
    conv(0, 40);
    chk(1'b0, "R8 held by remaining channel");
    conv(1, 40);
    chk(1'b1, "R8 released when all pass");
  endtask

  task automatic t_novalid();
    do_reset(2'b00);
    @(negedge clk);
    sample_ch_i = 2'd0;
    sample_temp_i = 8'd120;
    repeat (6) @(negedge clk);
    chk(1'b1, "R10 no strobe no effect");
    queue_i = 2'b01;
    conv(0, 120);
    chk(1'b1, "R10 idle values did not count");
    conv(0, 120);
    chk(1'b0, "R10 strobed run trips");
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_queue();
    t_equal();
    t_break();
    t_interleave();
    t_strap();
    t_sw();
    t_two();
    t_novalid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule